// File: doc/BRIEF.md
# Translation Buffer Lookup with Access Permission Check

This block is a small, fully associative translation buffer that turns a virtual address into a physical one and checks the access against the rights stored for its page. Each of the eight slots holds a valid flag, a virtual page number, a physical page number, a page-size flag that picks 4 KiB or 1 MiB pages, and three rights bits: read, write and execute. A lookup presents a virtual address and an access kind. One cycle later the block returns either a translated physical address, a miss fault or a permission fault.

The buffer never fills itself. When a lookup finds no slot, the block raises a miss fault so that system software can install the mapping through the load port and re-run the faulting access. Software writes a whole slot in one cycle by giving the slot index and all of its fields. Page-table walking, bus traffic and cache aliasing are outside the block.

Top module: `tlb_xlate_check`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `respValid`, `missFault`, `permFault` and `paddr` are 0, and every slot is invalid, so a lookup made right after reset misses.
- R2: `respValid` is high in exactly the cycles that follow a cycle with `lookValid` high; in all other cycles `respValid`, `missFault`, `permFault` and `paddr` are 0.
- R3: A lookup that matches no valid slot gives `missFault`=1, `permFault`=0 and `paddr`=0 in the response cycle.
- R4: A slot with `loadLarge`=0 is a 4 KiB page. It matches when all 20 bits of its page number equal `lookVaddr[31:12]`, and the result is `paddr = {ppn, lookVaddr[11:0]}`.
- R5: A slot with `loadLarge`=1 is a 1 MiB page. It matches when page-number bits [19:8] equal `lookVaddr[31:20]`. Bits [7:0] of the stored page numbers are ignored, and the result is `paddr = {ppn[19:8], lookVaddr[19:0]}`.
- R6: When several valid slots match, the slot with the lowest index supplies the translation and the rights.
- R7: Access kinds are encoded on `lookAcc` as 0 read, 1 write, 2 execute and 3 reserved. The rights bits are `loadPerm` bit 0 for read, bit 1 for write and bit 2 for execute. An access is allowed only when the bit for its kind is set. The reserved kind is never allowed.
- R8: A hit whose access is not allowed gives `permFault`=1, `missFault`=0 and `paddr`=0.
- R9: A slot written with `loadEn` high is used by lookups from the next cycle on. A lookup in the same cycle as the write still sees the old contents.
- R10: A miss leaves the slots unchanged, so repeating the same lookup misses again.
- R11: Writing a slot with `loadValid`=0 removes it from matching.
- R12: `missFault` and `permFault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Write the slot selected by loadIdx |
| loadIdx | input | 3 | Slot index for the write |
| loadValid | input | 1 | Valid flag written to the slot |
| loadVpn | input | 20 | Virtual page number written to the slot |
| loadPpn | input | 20 | Physical page number written to the slot |
| loadLarge | input | 1 | 1 selects a 1 MiB page, 0 selects a 4 KiB page |
| loadPerm | input | 3 | Rights: bit 0 read, bit 1 write, bit 2 execute |
| lookValid | input | 1 | Lookup request |
| lookVaddr | input | 32 | Virtual address to translate |
| lookAcc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| respValid | output | 1 | Response present, one cycle after the request |
| paddr | output | 32 | Translated address, 0 on a fault |
| missFault | output | 1 | No valid slot matched |
| permFault | output | 1 | A slot matched but the access is not allowed |

## Verification
The bench places overlapping mappings in several slots so that the lowest-index rule decides the result. A design that scanned from the top would return the wrong physical page. It mixes 1 MiB and 4 KiB pages whose low page-number bits differ, which catches a compare that uses too many bits and a splice of the in-page offset at the wrong boundary. It issues lookups in the same cycle as writes to the same slot, so a design that forwarded the new contents early would hit where it should miss. Reserved access kinds, pages with no rights, invalidated slots and repeated misses show any rights decoding or accidental refill, and every fault response is checked for a zero address.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int unsigned PERM_W = 3;
  localparam int unsigned PERM_R = 0;
  localparam int unsigned PERM_W_BIT = 1;
  localparam int unsigned PERM_X = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic writeEn;   // commit load port fields into the indexed slot
    logic passAddr;  // register the composed address, else register zero
  } tlb_strobe_t;

endpackage

// File: rtl/tlbDatapath.sv
module tlbDatapath
  import tlb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned ENTRIES   = 8,
  parameter int unsigned SMALL_OFS = 12,
  parameter int unsigned LARGE_OFS = 20,
  localparam int unsigned IDX_W    = $clog2(ENTRIES),
  localparam int unsigned VPN_W    = ADDR_W - SMALL_OFS
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlb_strobe_t        strobe,
  input  logic [IDX_W-1:0]   loadIdx,
  input  logic               loadValid,
  input  logic [VPN_W-1:0]   loadVpn,
  input  logic [VPN_W-1:0]   loadPpn,
  input  logic               loadLarge,
  input  logic [PERM_W-1:0]  loadPerm,
  input  logic [ADDR_W-1:0]  lookVaddr,
  input  logic [IDX_W-1:0]   winnerIdx,
  output logic [ENTRIES-1:0] hitVec,
  output logic [PERM_W-1:0]  winnerPerm,
  output logic [ADDR_W-1:0]  paddr
);

  localparam int unsigned LSH = LARGE_OFS - SMALL_OFS;

  logic               entValid [ENTRIES];
  logic [VPN_W-1:0]   entVpn   [ENTRIES];
  logic [VPN_W-1:0]   entPpn   [ENTRIES];
  logic               entLarge [ENTRIES];
  logic [PERM_W-1:0]  entPerm  [ENTRIES];

  always_ff @(posedge clk) begin
    for (int i = 0; i < int'(ENTRIES); i++) begin
      if (!rstN) begin
        entValid[i] <= 1'b0;
        entVpn[i]   <= '0;
        entPpn[i]   <= '0;
        entLarge[i] <= 1'b0;
        entPerm[i]  <= '0;
      end else if (strobe.writeEn && loadIdx == IDX_W'(i)) begin
        entValid[i] <= loadValid;
        entVpn[i]   <= loadVpn;
        entPpn[i]   <= loadPpn;
        entLarge[i] <= loadLarge;
        entPerm[i]  <= loadPerm;
      end
    end
  end

  logic [VPN_W-1:0] lookVpn;
  assign lookVpn = lookVaddr[ADDR_W-1:SMALL_OFS];

  for (genvar g = 0; g < int'(ENTRIES); g++) begin : gMatch
    logic hiEq, loEq;
    assign hiEq = entVpn[g][VPN_W-1:LSH] == lookVpn[VPN_W-1:LSH];
    assign loEq = entVpn[g][LSH-1:0] == lookVpn[LSH-1:0];
    assign hitVec[g] = entValid[g] && hiEq && (entLarge[g] || loEq);
  end

  logic [VPN_W-1:0]  selPpn;
  logic              selLarge;
  logic [ADDR_W-1:0] composed;

  always_comb begin
    selPpn     = entPpn[winnerIdx];
    selLarge   = entLarge[winnerIdx];
    winnerPerm = entPerm[winnerIdx];
    if (selLarge)
      composed = {selPpn[VPN_W-1:LSH], lookVaddr[LARGE_OFS-1:0]};
    else
      composed = {selPpn, lookVaddr[SMALL_OFS-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) paddr <= '0;
    else       paddr <= strobe.passAddr ? composed : '0;
  end

endmodule

// File: rtl/tlbControl.sv
module tlbControl
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadEn,
  input  logic               lookValid,
  input  logic [1:0]         lookAcc,
  input  logic [ENTRIES-1:0] hitVec,
  input  logic [PERM_W-1:0]  winnerPerm,
  output tlb_strobe_t        strobe,
  output logic [IDX_W-1:0]   winnerIdx,
  output logic               respValid,
  output logic               missFault,
  output logic               permFault
);

  logic anyHit, permOk;
  acc_e acc;

  assign anyHit = |hitVec;
  assign acc    = acc_e'(lookAcc);

  // scan downward so the lowest matching slot is the last one assigned
  always_comb begin
    winnerIdx = '0;
    for (int i = int'(ENTRIES) - 1; i >= 0; i--)
      if (hitVec[i]) winnerIdx = IDX_W'(i);
  end

  always_comb begin
    case (acc)
      ACC_READ:  permOk = winnerPerm[PERM_R];
      ACC_WRITE: permOk = winnerPerm[PERM_W_BIT];
      ACC_EXEC:  permOk = winnerPerm[PERM_X];
      default:   permOk = 1'b0;
    endcase
  end

  always_comb begin
    strobe.writeEn  = loadEn;
    strobe.passAddr = lookValid && anyHit && permOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      missFault <= 1'b0;
      permFault <= 1'b0;
    end else begin
      respValid <= lookValid;
      missFault <= lookValid && !anyHit;
      permFault <= lookValid && anyHit && !permOk;
    end
  end

endmodule

// File: rtl/tlb_xlate_check.sv
module tlb_xlate_check
  import tlb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned ENTRIES   = 8,
  parameter int unsigned SMALL_OFS = 12,
  parameter int unsigned LARGE_OFS = 20,
  localparam int unsigned IDX_W    = $clog2(ENTRIES),
  localparam int unsigned VPN_W    = ADDR_W - SMALL_OFS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [IDX_W-1:0]  loadIdx,
  input  logic              loadValid,
  input  logic [VPN_W-1:0]  loadVpn,
  input  logic [VPN_W-1:0]  loadPpn,
  input  logic              loadLarge,
  input  logic [PERM_W-1:0] loadPerm,
  input  logic              lookValid,
  input  logic [ADDR_W-1:0] lookVaddr,
  input  logic [1:0]        lookAcc,
  output logic              respValid,
  output logic [ADDR_W-1:0] paddr,
  output logic              missFault,
  output logic              permFault
);

  tlb_strobe_t        strobe;
  logic [IDX_W-1:0]   winnerIdx;
  logic [ENTRIES-1:0] hitVec;
  logic [PERM_W-1:0]  winnerPerm;

  tlbControl #(.ENTRIES(ENTRIES)) ctrl (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .lookValid(lookValid),
    .lookAcc(lookAcc), .hitVec(hitVec), .winnerPerm(winnerPerm),
    .strobe(strobe), .winnerIdx(winnerIdx), .respValid(respValid),
    .missFault(missFault), .permFault(permFault)
  );

  tlbDatapath #(
    .ADDR_W(ADDR_W), .ENTRIES(ENTRIES),
    .SMALL_OFS(SMALL_OFS), .LARGE_OFS(LARGE_OFS)
  ) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadIdx(loadIdx),
    .loadValid(loadValid), .loadVpn(loadVpn), .loadPpn(loadPpn),
    .loadLarge(loadLarge), .loadPerm(loadPerm), .lookVaddr(lookVaddr),
    .winnerIdx(winnerIdx), .hitVec(hitVec), .winnerPerm(winnerPerm),
    .paddr(paddr)
  );

endmodule

// File: rtl/tlbCheck.sv
module tlbCheck #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SMALL_OFS = 12
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 lookValid,
  input logic [SMALL_OFS-1:0] lookOfs,
  input logic                 respValid,
  input logic [ADDR_W-1:0]    paddr,
  input logic                 missFault,
  input logic                 permFault
);

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    lookValid |=> respValid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lookValid |=> !respValid && !missFault && !permFault && paddr == '0);

  assert_faults_exclusive_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(missFault && permFault));

  assert_miss_zero_addr_R3: assert property (@(posedge clk) disable iff (!rstN)
    missFault |-> respValid && paddr == '0);

  assert_perm_zero_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    permFault |-> respValid && paddr == '0);

  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    lookValid ##1 (respValid && !missFault && !permFault)
      |-> paddr[SMALL_OFS-1:0] == $past(lookOfs));

endmodule

bind tlb_xlate_check tlbCheck #(.ADDR_W(ADDR_W), .SMALL_OFS(SMALL_OFS)) chkInst (
  .clk(clk), .rstN(rstN), .lookValid(lookValid),
  .lookOfs(lookVaddr[SMALL_OFS-1:0]), .respValid(respValid), .paddr(paddr),
  .missFault(missFault), .permFault(permFault)
);

// File: tb/tlb_xlate_check_test.sv
module tlb_xlate_check_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        loadEn, loadValid, loadLarge, lookValid;
  logic [2:0]  loadIdx, loadPerm;
  logic [19:0] loadVpn, loadPpn;
  logic [31:0] lookVaddr, paddr;
  logic [1:0]  lookAcc;
  logic        respValid, missFault, permFault;

  int checks = 0;
  int failures = 0;

  // bench-side model of the slots
  logic        mV [8];
  logic [19:0] mVpn [8];
  logic [19:0] mPpn [8];
  logic        mL [8];
  logic [2:0]  mP [8];

  always #2 clk = ~clk;

  tlb_xlate_check uut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadIdx(loadIdx),
    .loadValid(loadValid), .loadVpn(loadVpn), .loadPpn(loadPpn),
    .loadLarge(loadLarge), .loadPerm(loadPerm), .lookValid(lookValid),
    .lookVaddr(lookVaddr), .lookAcc(lookAcc), .respValid(respValid),
    .paddr(paddr), .missFault(missFault), .permFault(permFault)
  );

  initial begin
    #2000000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void predict(input logic lv, input logic [31:0] va, input logic [1:0] acc,
                                  output logic eV, output logic eM, output logic eP,
                                  output logic [31:0] eA, output string tag);
    int w;
    logic ok;
    w = -1;
    eV = lv; eM = 0; eP = 0; eA = 0; tag = "R2";
    if (!lv) return;
    for (int i = 0; i < 8; i++) begin
      if (w < 0 && mV[i] &&
          (mL[i] ? (mVpn[i][19:8] == va[31:20]) : (mVpn[i] == va[31:12])))
        w = i;
    end
    if (w < 0) begin
      eM = 1; tag = "R3";
      return;
    end
    case (acc)
      2'd0: ok = mP[w][0];
      2'd1: ok = mP[w][1];
      2'd2: ok = mP[w][2];
      default: ok = 0;
    endcase
    if (!ok) begin
      eP = 1; tag = "R7_R8";
    end else if (mL[w]) begin
      eA = {mPpn[w][19:8], va[19:0]}; tag = "R5_R6";
    end else begin
      eA = {mPpn[w], va[11:0]}; tag = "R4_R6";
    end
  endfunction

  // one cycle: drive at negedge, apply edge, check the response at the next negedge
  task automatic step(input logic le, input logic [2:0] li, input logic lv_, input logic [19:0] vpn,
                      input logic [19:0] ppn, input logic lg, input logic [2:0] pm,
                      input logic qv, input logic [31:0] va, input logic [1:0] acc,
                      input string note);
    logic eV, eM, eP;
    logic [31:0] eA;
    string tag;
    loadEn = le; loadIdx = li; loadValid = lv_; loadVpn = vpn; loadPpn = ppn;
    loadLarge = lg; loadPerm = pm; lookValid = qv; lookVaddr = va; lookAcc = acc;
    predict(qv, va, acc, eV, eM, eP, eA, tag);
    @(posedge clk);
    if (le) begin
      mV[li] = lv_; mVpn[li] = vpn; mPpn[li] = ppn; mL[li] = lg; mP[li] = pm;
    end
    @(negedge clk);
    chk({note, " ", tag, " valid"}, 32'(respValid), 32'(eV));
    chk({note, " ", tag, " miss"},  32'(missFault), 32'(eM));
    chk({note, " ", tag, " perm R12"}, 32'(permFault), 32'(eP));
    chk({note, " ", tag, " paddr"}, paddr, eA);
  endtask

  task automatic load(input logic [2:0] li, input logic v, input logic [19:0] vpn,
                      input logic [19:0] ppn, input logic lg, input logic [2:0] pm);
    step(1, li, v, vpn, ppn, lg, pm, 0, 32'h0, 2'd0, "load");
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] acc, input string note);
    step(0, 3'd0, 0, 20'h0, 20'h0, 0, 3'd0, 1, va, acc, note);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin
      mV[i] = 0; mVpn[i] = 0; mPpn[i] = 0; mL[i] = 0; mP[i] = 0;
    end
    rstN = 0;
    loadEn = 0; loadIdx = 0; loadValid = 0; loadVpn = 0; loadPpn = 0;
    loadLarge = 0; loadPerm = 0; lookValid = 1; lookVaddr = 32'h1234_5678; lookAcc = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 32'(respValid), 0);
    chk("R1 reset miss", 32'(missFault), 0);
    chk("R1 reset perm", 32'(permFault), 0);
    chk("R1 reset paddr", paddr, 0);
    rstN = 1;
    lookValid = 0;
    @(negedge clk);
    chk("R1 first cycle valid", 32'(respValid), 0);

    look(32'h1234_5678, 2'd0, "R1 empty after reset");
    // same-cycle write and lookup: old contents win (R9)
    step(1, 3'd0, 1, 20'h12345, 20'hABCDE, 0, 3'b111, 1, 32'h1234_5678, 2'd0, "R9 same cycle");
    look(32'h1234_5678, 2'd0, "R9 next cycle");
    look(32'h1234_5FFF, 2'd1, "R4 small write");
    // repeated miss, no refill (R10)
    look(32'h7777_7000, 2'd0, "R10 first miss");
    look(32'h7777_7000, 2'd0, "R10 repeat miss");
    // priority: slots 2 and 5 share a page (R6)
    load(3'd5, 1, 20'h40000, 20'h55555, 0, 3'b111);
    load(3'd2, 1, 20'h40000, 20'h22222, 0, 3'b001);
    look(32'h4000_0ABC, 2'd0, "R6 lowest wins");
    look(32'h4000_0ABC, 2'd1, "R6 lowest rights");
    // large page, low vpn bits differ (R5)
    load(3'd3, 1, 20'h801FF, 20'hC0D00, 1, 3'b100);
    look(32'h8012_3456, 2'd2, "R5 large exec");
    look(32'h8012_3456, 2'd0, "R5 large read denied R8");
    look(32'h8012_3456, 2'd3, "R7 reserved kind");
    // invalidate (R11)
    load(3'd0, 0, 20'h12345, 20'hABCDE, 0, 3'b111);
    look(32'h1234_5678, 2'd0, "R11 invalidated");
    // idle cycle (R2)
    step(0, 3'd0, 0, 20'h0, 20'h0, 0, 3'd0, 0, 32'h4000_0000, 2'd0, "R2 idle");

    // random phase over a small page pool so that hits and overlaps are common
    for (int n = 0; n < 4000; n++) begin
      logic le, lq, lg;
      logic [19:0] vpn;
      logic [31:0] va;
      le  = ($urandom % 4) == 0;
      lq  = ($urandom % 8) != 0;
      lg  = ($urandom % 3) == 0;
      vpn = {10'h3A0 | 10'($urandom % 4), 2'b00, 8'($urandom % 3)};
      va  = {10'h3A0 | 10'($urandom % 4), 2'b00, 8'($urandom % 3), 12'($urandom)};
      step(le, 3'($urandom), ($urandom % 8) != 0, vpn, 20'($urandom), lg, 3'($urandom),
           lq, va, 2'($urandom), "rand");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule